// File: doc/BRIEF.md
# PPS-to-start phase offset counter

This block measures the fixed phase between a one-pulse-per-second timescale marker and a start strobe. The strobe comes from the same reference clock divided by a fixed ratio (16 by default). Nobody controls where the strobe lands relative to the PPS. Instead of realigning the divider, the block measures that phase once per resynchronisation event. It exports the phase as a signed additive correction. A downstream timestamp combiner adds it to a coarse count whose start indices are multiples of the divide ratio, which puts the sum on the timescale.

After a resync request the block arms and waits for the next PPS pulse. It counts reference clock cycles from that pulse to the first rising edge of the start strobe at or after it. The count is written to a held register, and a valid flag is raised. If no edge arrives within one strobe period, a sticky error flag is raised and the previous offset is kept. All inputs are synchronous to the reference clock. PPS and start are single-cycle pulses.

Top module: `pps_phase_meter`

## Requirements
- R1: While `rst` is high, and after it falls, `offset_out` is 0 and `offset_valid` and `meas_err` are 0.
- R2: Suppose a resync request is followed by a PPS pulse, and a start rising edge arrives c cycles after that pulse (c = 0 when both are in the same cycle, 0 ≤ c ≤ DIV-1). Then `offset_out` becomes c and `offset_valid` becomes 1.
- R3: The result is held in a field one bit wider than needed for DIV-1, with its top bit 0. It is sign-extended to OFS_W bits, so `offset_out` reads as a non-negative value from 0 to DIV-1, with DIV-1 = 15 by default. All bits above bit 3 are 0.
- R4: `offset_out` and `offset_valid` change on the same clock edge: the one that samples the start edge ending the measurement. After that they hold their values until the next successful measurement.
- R5: PPS and start pulses that arrive with no resync pending leave `offset_out`, `offset_valid` and `meas_err` unchanged.
- R6: If no start rising edge is seen in the PPS cycle or in the DIV-1 cycles after it, `meas_err` is set. That happens on the edge DIV-1 cycles after the PPS edge. `offset_out` and `offset_valid` keep their previous values, and a later start edge is ignored.
- R7: `meas_err` stays set until the next resync request. That request clears it on the edge that samples it.
- R8: A resync request takes priority over everything else. It aborts any measurement in progress, including a PPS in the same cycle, and re-arms the block for the next PPS.
- R9: A start rising edge means the start input is 1 and was 0 on the previous cycle. A start level that was already high in the cycle before the PPS does not end the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| resync_req | input | 1 | Counter resynchronisation request, one cycle |
| pps_in | input | 1 | Timescale one-pulse-per-second marker |
| start_in | input | 1 | Divided start strobe |
| offset_out | output | OFS_W | Signed PPS-to-start offset in reference cycles |
| offset_valid | output | 1 | A measurement has completed since reset |
| meas_err | output | 1 | Sticky: last measurement saw no start edge in time |

## Verification
A start edge arriving c cycles after the PPS updates the offset and valid flag on the very edge that samples it. The bench drives inputs on falling edges and checks one falling edge after the last stimulus, so each check lands exactly one edge after that sample. The error flag is due on the edge DIV-1 cycles after the PPS edge. The bench probes it just before that point, where it must still be clear, and again after it. A resync clears the error on its own edge, so the check follows the next falling edge. Each ignored-stimulus case is read back at the ports before any further resync is issued.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;
  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,
    PM_ARMED = 2'd1,
    PM_COUNT = 2'd2
  } pm_state_t;
endpackage

// File: rtl/start_rise_det.sv
module start_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  output logic rise_out
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strobe_in;
  end

  // R9: edge = high now, low one cycle ago
  assign rise_out = strobe_in & ~prev_q;
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import phase_meter_pkg::*;
#(
  parameter int DIV   = 16,
  parameter int CNT_W = $clog2(DIV) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync,
  input  logic             pps,
  input  logic             start_rise,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] meas
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  pm_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    done = 1'b0;
    fail = 1'b0;
    meas = cnt_q;
    if (!resync) begin
      unique case (state_q)
        PM_ARMED: begin
          if (pps && start_rise) begin
            done = 1'b1;
            meas = '0;
          end
        end
        PM_COUNT: begin
          if (start_rise)        done = 1'b1;
          else if (cnt_q == LAST) fail = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PM_IDLE;
      cnt_q   <= '0;
    end else if (resync) begin
      state_q <= PM_ARMED;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PM_ARMED: begin
          if (pps) begin
            if (start_rise) begin
              state_q <= PM_IDLE;
            end else begin
              state_q <= PM_COUNT;
              cnt_q   <= CNT_W'(1);
            end
          end
        end
        PM_COUNT: begin
          if (start_rise || cnt_q == LAST) begin
            state_q <= PM_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: state_q <= PM_IDLE;
      endcase
    end
  end

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_COUNT) |-> (cnt_q <= LAST && cnt_q != '0));

  a_r6_done_fail_excl: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));

  a_r8_resync_rearms: assert property (@(posedge clk) disable iff (rst)
    resync |=> (state_q == PM_ARMED));
endmodule

// File: rtl/pm_hold.sv
module pm_hold #(
  parameter int DIV   = 16,
  parameter int CNT_W = $clog2(DIV) + 1,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             fail,
  input  logic             clr_err,
  input  logic [CNT_W-1:0] meas,
  output logic [OFS_W-1:0] offset_q,
  output logic             valid_q,
  output logic             err_q
);
  localparam int EXT_W = OFS_W - CNT_W;

  logic [OFS_W-1:0] ext_meas;

  generate
    if (EXT_W > 0) begin : g_ext
      assign ext_meas = {{EXT_W{meas[CNT_W-1]}}, meas};
    end else begin : g_trunc
      assign ext_meas = meas[OFS_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= '0;
      valid_q  <= 1'b0;
    end else if (upd) begin
      offset_q <= ext_meas;
      valid_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          err_q <= 1'b0;
    else if (clr_err) err_q <= 1'b0;
    else if (fail)    err_q <= 1'b1;
  end

  a_r4_valid_keeps: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q);

  a_r4_offset_stable: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(offset_q));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_err) |=> err_q);

  a_r3_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(offset_q) >= 0) && ($signed(offset_q) < DIV));
endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter #(
  parameter int DIV   = 16,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             resync_req,
  input  logic             pps_in,
  input  logic             start_in,
  output logic [OFS_W-1:0] offset_out,
  output logic             offset_valid,
  output logic             meas_err
);
  localparam int CNT_W = $clog2(DIV) + 1;

  logic             start_rise;
  logic             done;
  logic             fail;
  logic [CNT_W-1:0] meas;

  start_rise_det u_edge (
    .clk       (clk),
    .rst       (rst),
    .strobe_in (start_in),
    .rise_out  (start_rise)
  );

  pm_ctrl #(.DIV(DIV), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .resync     (resync_req),
    .pps        (pps_in),
    .start_rise (start_rise),
    .done       (done),
    .fail       (fail),
    .meas       (meas)
  );

  pm_hold #(.DIV(DIV), .CNT_W(CNT_W), .OFS_W(OFS_W)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .upd      (done),
    .fail     (fail),
    .clr_err  (resync_req),
    .meas     (meas),
    .offset_q (offset_out),
    .valid_q  (offset_valid),
    .err_q    (meas_err)
  );

  a_r7_resync_clears: assert property (@(posedge clk) disable iff (rst)
    resync_req |=> !meas_err);

  a_r6_fail_keeps_offset: assert property (@(posedge clk) disable iff (rst)
    fail |=> ($stable(offset_out) && meas_err));
endmodule

// File: tb/sim_pps_phase_meter.sv
module sim_pps_phase_meter;
  localparam int DIV   = 16;
  localparam int OFS_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             resync_req = 1'b0;
  logic             pps_in = 1'b0;
  logic             start_in = 1'b0;
  logic [OFS_W-1:0] offset_out;
  logic             offset_valid;
  logic             meas_err;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pps_phase_meter #(.DIV(DIV), .OFS_W(OFS_W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .resync_req   (resync_req),
    .pps_in       (pps_in),
    .start_in     (start_in),
    .offset_out   (offset_out),
    .offset_valid (offset_valid),
    .meas_err     (meas_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle of inputs on a falling edge
  task automatic cyc(input logic r, input logic p, input logic s);
    @(negedge clk);
    resync_req = r;
    pps_in     = p;
    start_in   = s;
  endtask

  task automatic arm();
    cyc(1, 0, 0);
    cyc(0, 0, 0);
  endtask

  // PPS now, start edge c cycles later; afterwards results are checkable
  task automatic pps_then_start(input int c);
    for (int i = 0; i <= c; i++) cyc(0, i == 0, i == c);
    cyc(0, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 offset", int'(offset_out), 0);
    chk("R1 valid", int'(offset_valid), 0);
    chk("R1 err", int'(meas_err), 0);
  endtask

  task automatic t_basic(input int c);
    arm();
    pps_then_start(c);
    chk("R2 offset", int'(offset_out), c);
    chk("R4 valid", int'(offset_valid), 1);
    chk("R3 upper bits zero", int'(offset_out[OFS_W-1:4]), 0);
  endtask

  task automatic t_update_edge();
    // R4: just before the start edge is sampled, the old value still shows
    arm();
    for (int i = 0; i <= 6; i++) cyc(0, i == 0, i == 6);
    chk("R4 before edge", int'(offset_out), DIV - 1);
    cyc(0, 0, 0);
    chk("R4 after edge", int'(offset_out), 6);
  endtask

  task automatic t_no_resync();
    pps_then_start(3);
    chk("R5 offset unchanged", int'(offset_out), 6);
    chk("R5 err unchanged", int'(meas_err), 0);
  endtask

  task automatic t_timeout();
    arm();
    // PPS at step 0; no edge through step DIV-1; start at step DIV is too late
    for (int i = 0; i <= DIV; i++) begin
      cyc(0, i == 0, i == DIV);
      if (i == DIV - 1) chk("R6 err not yet", int'(meas_err), 0);
    end
    cyc(0, 0, 0);
    chk("R6 err set", int'(meas_err), 1);
    chk("R6 offset kept", int'(offset_out), 6);
    chk("R6 valid kept", int'(offset_valid), 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    chk("R7 err sticky", int'(meas_err), 1);
    cyc(1, 0, 0);
    cyc(0, 0, 0);
    chk("R7 err cleared", int'(meas_err), 0);
  endtask

  task automatic t_restart();
    arm();
    cyc(0, 1, 0);
    cyc(0, 0, 0);
    cyc(1, 0, 0);            // abort measurement
    cyc(0, 0, 1);            // start while only armed
    cyc(0, 0, 0);
    chk("R8 aborted no update", int'(offset_out), 6);
    cyc(1, 1, 0);            // resync with PPS: PPS ignored
    cyc(0, 0, 1);
    cyc(0, 0, 0);
    chk("R8 same-cycle pps ignored", int'(offset_out), 6);
    pps_then_start(5);
    chk("R8 restart result", int'(offset_out), 5);
  endtask

  task automatic t_held_start();
    arm();
    cyc(0, 0, 1);            // start high before PPS
    cyc(0, 1, 1);            // still high at PPS: no edge
    for (int i = 1; i <= 4; i++) cyc(0, 0, i == 4);
    cyc(0, 0, 0);
    chk("R9 held level ignored", int'(offset_out), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    t_reset();
    t_basic(0);
    t_basic(7);
    t_basic(DIV - 1);
    t_update_edge();
    t_no_resync();
    t_timeout();
    t_restart();
    t_held_start();
    t_basic(2);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule